// File: doc/BRIEF.md
# Oversampled Serial Receiver with Triple-Sample Noise Detection

The block receives asynchronous serial frames on one line that idles high. An enable pulse at sixteen times the bit rate, made by a divider outside the block, paces all timing; with a 57,600 bit/s line that enable runs at 921.6 kHz. A frame is one low start bit, the data bits least significant first, an optional parity bit and one high stop bit. The receiver waits for the line to fall, times each bit from that edge and recovers the byte.

Each bit, the start and stop bits included, is sampled three times around its centre, one oversample tick apart. The majority of the three samples gives the bit's value. If the three samples of any bit in a frame differ, a noise flag is raised for that frame, yet the voted value is still used. Parity checking and its sense are set by static configuration pins. A low stop bit gives a framing error, and the receiver then ignores the line until it sees it high again. The byte and the three flags are presented together with a one-cycle strobe.

Top module: `serial_rx_vote`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, data_o, noise_err_o, par_err_o and frame_err_o are all 0.
- R2: When the receiver is idle, a tick_i on which the synchronised line is low is a start detection and is counted as tick 0 of the start bit. If the vote of the start bit is high, the frame is abandoned with no strobe and the receiver is idle again.
- R3: Each bit is sampled on its ticks 7, 8 and 9, where tick 0 of a bit is 16 ticks after tick 0 of the bit before it. The bit value is the majority of the three samples. Data bits arrive least significant first, and data_o bit i is the i-th data bit received.
- R4: If the three samples of any bit in a frame (start, data, parity or stop) are not all equal, noise_err_o is 1 with that frame's strobe. The data still uses the majority values.
- R5: With par_en_i=1, one parity bit follows the data. With par_odd_i=0 the count of ones in data and parity must be even, and with par_odd_i=1 it must be odd. A mismatch sets par_err_o. With par_en_i=0 there is no parity bit and par_err_o stays 0.
- R6: A stop bit whose vote is low sets frame_err_o. No start is then detected until the line has been seen high on a tick.
- R7: valid_o is high for exactly one clock, in the clock after the tick that is tick 15 of the stop bit. data_o and the flags change together with it and hold until the next start detection, which clears the flags and leaves data_o unchanged.
- R8: After reset no start is detected until the line has been seen high on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock enable at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idle high, asynchronous |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| data_o | output | DATA_W | Received byte |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| noise_err_o | output | 1 | Disagreeing samples in some bit of the frame |
| par_err_o | output | 1 | Parity mismatch |
| frame_err_o | output | 1 | Stop bit received low |

## Verification
The assertions assume that tick_i is a single-cycle pulse with at least a few clocks between pulses, and that par_en_i and par_odd_i change only while no frame is in progress. The bench drives tick_i as one pulse every four clocks. It changes rxd_i three clocks ahead of each tick, so the synchroniser has settled before the tick arrives. It changes the parity pins only between frames. Glitches are single flipped oversample slots, so they can disturb a bit's samples but never its majority value.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  input  logic run_i,
  output logic take0_o,
  output logic take1_o,
  output logic take2_o,
  output logic bit_end_o
);
  localparam int PH_W = $clog2(OSR);
  localparam int MID  = OSR / 2;
  localparam logic [PH_W-1:0] PH_T0   = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_T1   = PH_W'(MID);
  localparam logic [PH_W-1:0] PH_T2   = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  // phase_q holds the phase of the next tick
  logic [PH_W-1:0] phase_q;
  logic            adv;

  assign adv = tick_i & run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clear_i) phase_q <= PH_W'(1);
    else if (adv)     phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
  end

  assign take0_o   = adv & (phase_q == PH_T0);
  assign take1_o   = adv & (phase_q == PH_T1);
  assign take2_o   = adv & (phase_q == PH_T2);
  assign bit_end_o = adv & (phase_q == PH_LAST);
endmodule

// File: rtl/rx_triple_vote.sv
module rx_triple_vote
  import serial_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic take0_i,
  input  logic take1_i,
  output logic vote_o,
  output logic noisy_o
);
  logic s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      if (take0_i) s0_q <= line_i;
      if (take1_i) s1_q <= line_i;
    end
  end

  // valid in the cycle of the third sample
  assign vote_o  = maj3(s0_q, s1_q, line_i);
  assign noisy_o = !((s0_q == s1_q) && (s1_q == line_i));
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              noise_err_o,
  output logic              par_err_o,
  output logic              frame_err_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic              line;
  logic              busy, start_det;
  logic              take0, take1, take2, bit_end;
  logic              vote, noisy;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] shreg_q, data_q;
  logic              noise_acc_q, par_acc_q, par_bad_q, stop_ok_q;
  logic              valid_q, noise_q, par_q, frame_q;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line)
  );

  assign busy      = (state_q == ST_START) || (state_q == ST_DATA) ||
                     (state_q == ST_PAR)   || (state_q == ST_STOP);
  assign start_det = (state_q == ST_IDLE) && tick_i && !line;

  rx_bit_timer #(.OSR(OSR)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clear_i  (start_det),
    .run_i    (busy),
    .take0_o  (take0),
    .take1_o  (take1),
    .take2_o  (take2),
    .bit_end_o(bit_end)
  );

  rx_triple_vote u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line),
    .take0_i(take0),
    .take1_i(take1),
    .vote_o (vote),
    .noisy_o(noisy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HUNT;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      data_q      <= '0;
      noise_acc_q <= 1'b0;
      par_acc_q   <= 1'b0;
      par_bad_q   <= 1'b0;
      stop_ok_q   <= 1'b0;
      valid_q     <= 1'b0;
      noise_q     <= 1'b0;
      par_q       <= 1'b0;
      frame_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (take2) noise_acc_q <= noise_acc_q | noisy;
      unique case (state_q)
        ST_HUNT: begin
          if (tick_i && line) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (start_det) begin
            state_q     <= ST_START;
            noise_q     <= 1'b0;
            par_q       <= 1'b0;
            frame_q     <= 1'b0;
            noise_acc_q <= 1'b0;
            par_acc_q   <= 1'b0;
            par_bad_q   <= 1'b0;
          end
        end
        ST_START: begin
          if (take2 && vote) begin
            state_q <= ST_IDLE;
          end else if (bit_end) begin
            state_q   <= ST_DATA;
            bit_cnt_q <= '0;
          end
        end
        ST_DATA: begin
          if (take2) begin
            shreg_q   <= {vote, shreg_q[DATA_W-1:1]};
            par_acc_q <= par_acc_q ^ vote;
          end
          if (bit_end) begin
            if (bit_cnt_q == LAST_BIT) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else                       bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (take2)   par_bad_q <= (par_acc_q ^ vote) != par_odd_i;
          if (bit_end) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (take2) stop_ok_q <= vote;
          if (bit_end) begin
            valid_q <= 1'b1;
            data_q  <= shreg_q;
            noise_q <= noise_acc_q;
            par_q   <= par_en_i & par_bad_q;
            frame_q <= !stop_ok_q;
            state_q <= stop_ok_q ? ST_IDLE : ST_HUNT;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign noise_err_o = noise_q;
  assign par_err_o   = par_q;
  assign frame_err_o = frame_q;
endmodule

// File: rtl/serial_rx_vote_chk.sv
module serial_rx_vote_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              par_en_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              noise_err_o,
  input logic              par_err_o,
  input logic              frame_err_o
);
  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_strobe_follows_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));

  assert_data_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  assert_flags_only_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !$stable({noise_err_o, par_err_o, frame_err_o}))
      |-> ({noise_err_o, par_err_o, frame_err_o} == 3'b000));

  assert_no_par_err_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !par_err_o);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_quiet_R1: assert (!valid_o);
endmodule

bind serial_rx_vote serial_rx_vote_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .par_en_i   (par_en_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .noise_err_o(noise_err_o),
  .par_err_o  (par_err_o),
  .frame_err_o(frame_err_o)
);

// File: tb/serial_rx_vote_test.sv
module serial_rx_vote_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [7:0] data;
    logic       noise;
    logic       par;
    logic       frame;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, noise_err_o, par_err_o, frame_err_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t exp_q[$];
  logic prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_rx_vote uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .data_o(data_o),
    .valid_o(valid_o), .noise_err_o(noise_err_o), .par_err_o(par_err_o),
    .frame_err_o(frame_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one oversample slot: line value, then a tick four clocks later
  task automatic slot(input logic v);
    rxd_i = v;
    repeat (3) @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n, input logic v);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  // fb/fs: bit index and slot to flip (-1 for none)
  task automatic send_frame(input logic [7:0] d, input int fb, input int fs,
                            input logic bad_par, input logic stop_v);
    logic [10:0] bits;
    int          nb;
    logic        p;
    exp_t        e;
    bits = '0;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    nb = par_en_i ? 11 : 10;
    p = (^d) ^ par_odd_i ^ bad_par;
    if (par_en_i) bits[9] = p;
    bits[nb-1] = stop_v;
    e.data  = d;
    e.noise = (fb >= 0) && (fs >= 7) && (fs <= 9);
    e.par   = par_en_i & bad_par;
    e.frame = !stop_v;
    exp_q.push_back(e);
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < 16; s++) slot(bits[b] ^ ((b == fb) && (s == fs)));
      if (b == 0)
        check("R7 flags cleared at start", {noise_err_o, par_err_o, frame_err_o}, 0);
    end
    check("R7 strobe after stop tick 15", valid_o, 1);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o && prev_valid) check("R7 strobe width", 2, 1);
      if (valid_o && !prev_valid) begin
        if (exp_q.size() == 0) begin
          check("R2/R6/R8 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R3 data", data_o, e.data);
          check("R4 noise flag", noise_err_o, e.noise);
          check("R5 parity flag", par_err_o, e.par);
          check("R6 framing flag", frame_err_o, e.frame);
        end
      end
    end
    prev_valid <= valid_o;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rxd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R1 valid in reset", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 outputs after reset", {data_o, valid_o, noise_err_o, par_err_o, frame_err_o}, 0);

    // R8: line low from reset must not start a frame
    idle(180, 1'b0);
    idle(5, 1'b1);
    send_frame(8'hA5, -1, 0, 1'b0, 1'b1);
    idle(3, 1'b1);
    send_frame(8'h00, -1, 0, 1'b0, 1'b1);
    send_frame(8'hFF, -1, 0, 1'b0, 1'b1);
    idle(2, 1'b1);

    // R4: one flipped sample per frame in several bit positions
    send_frame(8'h3C, 4, 8, 1'b0, 1'b1);
    idle(2, 1'b1);
    send_frame(8'h96, 0, 9, 1'b0, 1'b1);
    idle(2, 1'b1);
    send_frame(8'h5A, 9, 7, 1'b0, 1'b1);
    idle(2, 1'b1);
    // R3: flip outside the sample window is invisible
    send_frame(8'h81, 2, 3, 1'b0, 1'b1);
    idle(2, 1'b1);

    // R2: short low pulse is a false start
    idle(3, 1'b0);
    idle(30, 1'b1);
    check("R2 no strobe after false start", exp_q.size(), 0);
    send_frame(8'h12, -1, 0, 1'b0, 1'b1);
    idle(2, 1'b1);

    // R5: parity modes
    par_en_i = 1'b1; par_odd_i = 1'b0;
    send_frame(8'h37, -1, 0, 1'b0, 1'b1);
    idle(2, 1'b1);
    send_frame(8'h37, -1, 0, 1'b1, 1'b1);
    idle(2, 1'b1);
    par_odd_i = 1'b1;
    send_frame(8'hC4, -1, 0, 1'b0, 1'b1);
    idle(2, 1'b1);
    send_frame(8'hC4, 9, 8, 1'b1, 1'b1);
    idle(2, 1'b1);
    par_en_i = 1'b0;

    // R6: framing error, line held low afterwards
    send_frame(8'h6E, -1, 0, 1'b0, 1'b0);
    idle(40, 1'b0);
    idle(4, 1'b1);
    send_frame(8'h29, -1, 0, 1'b0, 1'b1);
    idle(4, 1'b1);

    check("R7 all frames strobed", exp_q.size(), 0);
    check("R7 data held after strobe", data_o, 8'h29);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule